// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Byte

This block is the data path of a small accumulator-style processor core. Each cycle in which `op_en` is high, it takes two 8-bit operands, a 4-bit operation select and the current lower status byte. One clock later it presents the 8-bit result and the new status byte. The surrounding sequencer fetches operands, writes the result to a register and writes the status byte back. When `op_en` is low, both outputs hold their values.

Two bits of the incoming status byte change how the unit behaves. The carry-mode bit decides whether add, subtract and rotate use the carry flag. The compare-mode bit decides whether compare is unsigned or signed. Arithmetic operations update carry, nibble carry, overflow and the condition code. Logical, load, compare and mask operations update only the condition code. Rotate and decimal adjust leave the condition code alone.

Status byte layout: bits 7:6 condition code, bit 5 nibble carry, bit 4 spare, bit 3 carry mode, bit 2 overflow, bit 1 compare mode, bit 0 carry.

Top module: `alu8_status`

## Requirements
- R1: While `rst_n` is low, `res_out` and `psl_out` are 0x00.
- R2: A clock edge with `op_en` high loads both outputs from the inputs seen at that edge. A clock edge with `op_en` low leaves both outputs unchanged.
- R3: Load (code 0, result = `opb`), AND (code 3), inclusive OR (code 4) and exclusive OR (code 5) set the condition code from the result: 00 for zero, 01 for nonzero with bit 7 clear, 10 for bit 7 set.
- R4: Add (code 1) gives `opa + opb + cin`, where cin is the carry bit when the carry-mode bit is 1 and 0 otherwise. Bit 0 takes the carry out of bit 7 and bit 5 the carry out of bit 3. Bit 2 is set when the signed sum is outside -128..127. The condition code is set as in R3.
- R5: Subtract (code 2) gives `opa - opb - bin`, where bin is the inverse of the carry bit when carry mode is 1 and 0 otherwise. Bit 0 is 1 when no borrow leaves bit 7, and bit 5 is 1 when no borrow leaves bit 3. Overflow and the condition code are set as in R4.
- R6: The operations of R3 keep status bits 5:0 equal to those of `psl_in`.
- R7: Compare (code 6) outputs `opa` as result and writes only the condition code: 00 equal, 01 `opa` greater, 10 `opa` less. The ordering is unsigned when status bit 1 is 1 and two's complement when it is 0.
- R8: Mask test (code 7) outputs `opa` and writes only the condition code: 00 when every bit set in `opb` is also set in `opa`, otherwise 10.
- R9: Rotate left (code 8) and right (code 9) act on the 9-bit value {carry, `opa`} when carry mode is 1, and then only bit 0 of the status changes. With carry mode 0 they rotate `opa` alone and the status passes through unchanged.
- R10: Decimal adjust (code 10) adds 0xA modulo 16 to the high nibble of `opa` when the carry bit is 0, and to the low nibble when the nibble-carry bit is 0. The status passes through unchanged.
- R11: Codes 11 to 15 output `opa` and pass the status byte through unchanged.
- R12: Status bits 4, 3 and 1 always pass from `psl_in` to `psl_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Perform an operation at this edge |
| op_sel | input | 4 | Operation code |
| opa | input | 8 | Register operand |
| opb | input | 8 | Second operand, immediate or mask |
| psl_in | input | 8 | Current lower status byte |
| res_out | output | 8 | Registered result |
| psl_out | output | 8 | Registered new status byte |

## Verification
Directed cases probe each edge of the adder. 0x7F+0x01 gives overflow without carry, and 0xFF+0x01 gives carry with a zero result. Subtracting a larger value produces a borrow. A set carry changes the sum only when carry mode is on. Compare is run on 0x80 against 0x01 under both compare modes, because the two orderings disagree on that pair. Rotates and decimal adjust are run with each flag setting, which separates the 8-bit and 9-bit rotate paths and the two nibble corrections. A long random stream with `op_en` toggling then covers every operation code against the reference model every cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 4;

  localparam int CC_HI = 7;
  localparam int CC_LO = 6;
  localparam int NCY_B = 5;
  localparam int CWM_B = 3;
  localparam int OVF_B = 2;
  localparam int UCM_B = 1;
  localparam int CY_B  = 0;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_IOR   = 4'd4,
    OP_EOR   = 4'd5,
    OP_CMP   = 4'd6,
    OP_TMASK = 4'd7,
    OP_ROL   = 4'd8,
    OP_ROR   = 4'd9,
    OP_DADJ  = 4'd10
  } alu_op_e;

  function automatic logic [1:0] cc_of(input logic [DW-1:0] v);
    if (v == '0)       return 2'b00;
    else if (v[DW-1])  return 2'b10;
    else               return 2'b01;
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cy_mode,
  input  logic          cy_in,
  output logic [DW-1:0] sum,
  output logic          cy_out,
  output logic          ncy_out,
  output logic          ovf_out
);
  logic [DW-1:0] b_eff;
  logic          ci;
  logic [NW:0]   lo_sum;
  logic [NW:0]   hi_sum;

  always_comb begin
    b_eff   = sub ? ~b : b;
    ci      = cy_mode ? cy_in : sub;
    lo_sum  = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, ci};
    hi_sum  = {1'b0, a[DW-1:NW]} + {1'b0, b_eff[DW-1:NW]} + {{NW{1'b0}}, lo_sum[NW]};
    sum     = {hi_sum[NW-1:0], lo_sum[NW-1:0]};
    cy_out  = hi_sum[NW];
    ncy_out = lo_sum[NW];
    ovf_out = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [OPW-1:0] op,
  input  logic           unsigned_cmp,
  output logic [DW-1:0]  res,
  output logic [1:0]     cmp_cc,
  output logic [1:0]     mask_cc
);
  logic a_lt;
  logic a_eq;

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_IOR:  res = a | b;
      OP_EOR:  res = a ^ b;
      default: res = b;
    endcase
    a_eq = (a == b);
    a_lt = unsigned_cmp ? (a < b) : ($signed(a) < $signed(b));
    if (a_eq)      cmp_cc = 2'b00;
    else if (a_lt) cmp_cc = 2'b10;
    else           cmp_cc = 2'b01;
    mask_cc = ((a & b) == b) ? 2'b00 : 2'b10;
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  logic [DW-1:0]  a,
  input  logic [OPW-1:0] op,
  input  logic           cy_mode,
  input  logic           cy_in,
  input  logic           ncy_in,
  output logic [DW-1:0]  res,
  output logic           cy_out
);
  localparam logic [NW-1:0] DEC_FIX = NW'(10);
  logic [DW-1:0] adj;
  logic [1:0]    fix_need;

  assign fix_need = {~cy_in, ~ncy_in};

  genvar n;
  generate
    for (n = 0; n < 2; n++) begin : g_nib
      assign adj[n*NW +: NW] = a[n*NW +: NW] + (fix_need[n] ? DEC_FIX : '0);
    end
  endgenerate

  always_comb begin
    res    = a;
    cy_out = cy_in;
    case (op)
      OP_ROL: begin
        res    = {a[DW-2:0], cy_mode ? cy_in : a[DW-1]};
        cy_out = cy_mode ? a[DW-1] : cy_in;
      end
      OP_ROR: begin
        res    = {cy_mode ? cy_in : a[0], a[DW-1:1]};
        cy_out = cy_mode ? a[0] : cy_in;
      end
      OP_DADJ: res = adj;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_en,
  input  logic [OPW-1:0] op_sel,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic [DW-1:0]  psl_in,
  output logic [DW-1:0]  res_out,
  output logic [DW-1:0]  psl_out
);
  logic [DW-1:0] as_sum;
  logic          as_cy, as_ncy, as_ovf;
  logic [DW-1:0] lg_res;
  logic [1:0]    cmp_cc, mask_cc;
  logic [DW-1:0] sh_res;
  logic          sh_cy;
  logic [DW-1:0] res_d, psl_d;
  logic [DW-1:0] res_q, psl_q;

  alu8_addsub u_addsub (
    .a(opa), .b(opb), .sub(op_sel == OP_SUB),
    .cy_mode(psl_in[CWM_B]), .cy_in(psl_in[CY_B]),
    .sum(as_sum), .cy_out(as_cy), .ncy_out(as_ncy), .ovf_out(as_ovf)
  );

  alu8_logic u_logic (
    .a(opa), .b(opb), .op(op_sel), .unsigned_cmp(psl_in[UCM_B]),
    .res(lg_res), .cmp_cc(cmp_cc), .mask_cc(mask_cc)
  );

  alu8_shift u_shift (
    .a(opa), .op(op_sel), .cy_mode(psl_in[CWM_B]),
    .cy_in(psl_in[CY_B]), .ncy_in(psl_in[NCY_B]),
    .res(sh_res), .cy_out(sh_cy)
  );

  always_comb begin
    res_d = opa;
    psl_d = psl_in;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        res_d               = as_sum;
        psl_d[CC_HI:CC_LO]  = cc_of(as_sum);
        psl_d[NCY_B]        = as_ncy;
        psl_d[OVF_B]        = as_ovf;
        psl_d[CY_B]         = as_cy;
      end
      OP_LOAD, OP_AND, OP_IOR, OP_EOR: begin
        res_d               = lg_res;
        psl_d[CC_HI:CC_LO]  = cc_of(lg_res);
      end
      OP_CMP:   psl_d[CC_HI:CC_LO] = cmp_cc;
      OP_TMASK: psl_d[CC_HI:CC_LO] = mask_cc;
      OP_ROL, OP_ROR, OP_DADJ: begin
        res_d       = sh_res;
        psl_d[CY_B] = sh_cy;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      psl_q <= '0;
    end else if (op_en) begin
      res_q <= res_d;
      psl_q <= psl_d;
    end
  end

  assign res_out = res_q;
  assign psl_out = psl_q;
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
  import alu8_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           op_en,
  input logic [OPW-1:0] op_sel,
  input logic [DW-1:0]  opa,
  input logic [DW-1:0]  opb,
  input logic [DW-1:0]  psl_in,
  input logic [DW-1:0]  res_out,
  input logic [DW-1:0]  psl_out
);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> ($stable(res_out) && $stable(psl_out)));

  // R6
  logic_flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_sel == OP_LOAD || op_sel == OP_AND || op_sel == OP_IOR || op_sel == OP_EOR))
    |=> psl_out[5:0] == $past(psl_in[5:0]));

  // R7
  cmp_keeps_opa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == OP_CMP) |=> (res_out == $past(opa) && psl_out[5:0] == $past(psl_in[5:0])));

  // R3
  cc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel <= OP_TMASK) |=> psl_out[7:6] != 2'b11);

  // R4
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == OP_ADD) |=>
      psl_out[OVF_B] == (($past(opa[7]) == $past(opb[7])) && (res_out[7] != $past(opa[7]))));

  // R12
  mode_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_en |=> (psl_out[4] == $past(psl_in[4]) && psl_out[3] == $past(psl_in[3])
               && psl_out[1] == $past(psl_in[1])));

  // R11
  reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel > OP_DADJ) |=> (res_out == $past(opa) && psl_out == $past(psl_in)));

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_val_chk: assert (res_out == '0 && psl_out == '0);
    end
  end
endmodule

bind alu8_status alu8_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel), .opa(opa), .opb(opb),
  .psl_in(psl_in), .res_out(res_out), .psl_out(psl_out)
);

// File: tb/alu8_status_test.sv
module alu8_status_test;
  logic       clk;
  logic       rst_n;
  logic       op_en;
  logic [3:0] op_sel;
  logic [7:0] opa, opb, psl_in;
  logic [7:0] res_out, psl_out;

  int total = 0;
  int bad   = 0;
  int exp_res = 0;
  int exp_psl = 0;
  bit done = 0;

  alu8_status uut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel), .opa(opa), .opb(opb),
    .psl_in(psl_in), .res_out(res_out), .psl_out(psl_out)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int ccv(input int v);
    if (v == 0) return 0;
    if (v > 127) return 2;
    return 1;
  endfunction

  // behavioural model: returns {res,psl} as res*256+psl
  function automatic int model(input int op, input int a, input int b, input int p);
    int r, s, c, nc, ov, wc, cy, ncy, full, lo, hi, sv;
    r = a; s = p;
    wc = (p >> 3) & 1; cy = p & 1; ncy = (p >> 5) & 1;
    case (op)
      1: begin
        c = wc ? cy : 0;
        full = a + b + c; r = full % 256;
        nc = ((a % 16) + (b % 16) + c) > 15;
        sv = sgn(a) + sgn(b) + c; ov = (sv > 127 || sv < -128);
        s = (ccv(r) << 6) | (nc << 5) | (p & 8'h1A) | (ov << 2) | (full > 255 ? 1 : 0);
      end
      2: begin
        c = wc ? (1 - cy) : 0;
        full = a - b - c; r = (full + 512) % 256;
        nc = ((a % 16) - (b % 16) - c) >= 0;
        sv = sgn(a) - sgn(b) - c; ov = (sv > 127 || sv < -128);
        s = (ccv(r) << 6) | (nc << 5) | (p & 8'h1A) | (ov << 2) | (full >= 0 ? 1 : 0);
      end
      0, 3, 4, 5: begin
        r = (op == 0) ? b : (op == 3) ? (a & b) : (op == 4) ? (a | b) : (a ^ b);
        s = (ccv(r) << 6) | (p & 8'h3F);
      end
      6: begin
        if (((p >> 1) & 1) == 1) c = (a == b) ? 0 : (a > b) ? 1 : 2;
        else c = (sgn(a) == sgn(b)) ? 0 : (sgn(a) > sgn(b)) ? 1 : 2;
        s = (c << 6) | (p & 8'h3F);
      end
      7: s = ((((a & b) == b) ? 0 : 2) << 6) | (p & 8'h3F);
      8: begin
        if (wc) begin full = a * 2 + cy; r = full % 256; s = (p & 8'hFE) | (full >> 8); end
        else r = ((a * 2) % 256) | (a >> 7);
      end
      9: begin
        if (wc) begin r = (cy << 7) | (a >> 1); s = (p & 8'hFE) | (a & 1); end
        else r = ((a & 1) << 7) | (a >> 1);
      end
      10: begin
        lo = a % 16; hi = a / 16;
        if (ncy == 0) lo = (lo + 10) % 16;
        if (cy == 0)  hi = (hi + 10) % 16;
        r = hi * 16 + lo;
      end
      default: ;
    endcase
    return r * 256 + s;
  endfunction

  task automatic check(input string req);
    total++;
    if (res_out !== 8'(exp_res) || psl_out !== 8'(exp_psl)) begin
      bad++;
      $display("FAIL %s: res=%h psl=%h expected res=%h psl=%h", req, res_out, psl_out,
               8'(exp_res), 8'(exp_psl));
    end
  endtask

  // drive at negedge, model updates at the edge, compare at next negedge
  task automatic step(input bit en, input int op, input int a, input int b, input int p,
                      input string req);
    int m;
    op_en = en; op_sel = 4'(op); opa = 8'(a); opb = 8'(b); psl_in = 8'(p);
    @(posedge clk);
    if (en) begin
      m = model(op, a, b, p);
      exp_res = m / 256; exp_psl = m % 256;
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    rst_n = 0; op_en = 0; op_sel = 0; opa = 0; opb = 0; psl_in = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");

    step(1, 0, 8'h00, 8'h80, 8'h3F, "R3 load negative");
    step(1, 3, 8'hF0, 8'h0F, 8'h15, "R3 and zero");
    step(1, 4, 8'h01, 8'h20, 8'h00, "R3 ior positive");
    step(1, 5, 8'hAA, 8'h55, 8'h3F, "R6 eor flags kept");
    step(1, 1, 8'h7F, 8'h01, 8'h00, "R4 overflow");
    step(1, 1, 8'hFF, 8'h01, 8'h00, "R4 carry zero");
    step(1, 1, 8'h10, 8'h20, 8'h01, "R4 carry ignored");
    step(1, 1, 8'h10, 8'h20, 8'h09, "R4 carry in");
    step(1, 1, 8'h0F, 8'h01, 8'h00, "R4 nibble carry");
    step(1, 2, 8'h10, 8'h20, 8'h00, "R5 borrow");
    step(1, 2, 8'h80, 8'h01, 8'h00, "R5 overflow");
    step(1, 2, 8'h20, 8'h10, 8'h08, "R5 borrow in");
    step(1, 2, 8'h20, 8'h10, 8'h09, "R5 no borrow in");
    step(1, 6, 8'h80, 8'h01, 8'h02, "R7 unsigned greater");
    step(1, 6, 8'h80, 8'h01, 8'h00, "R7 signed less");
    step(1, 6, 8'h42, 8'h42, 8'h25, "R7 equal");
    step(1, 7, 8'hF3, 8'h33, 8'h00, "R8 all set");
    step(1, 7, 8'hF3, 8'h0C, 8'h00, "R8 some clear");
    step(1, 8, 8'h81, 8'h00, 8'h08, "R9 rol through carry");
    step(1, 8, 8'h81, 8'h00, 8'h01, "R9 rol 8 bit");
    step(1, 9, 8'h01, 8'h00, 8'h09, "R9 ror through carry");
    step(1, 9, 8'h01, 8'h00, 8'h00, "R9 ror 8 bit");
    step(1, 10, 8'h66, 8'h00, 8'h00, "R10 both nibbles");
    step(1, 10, 8'h66, 8'h00, 8'h21, "R10 no fix");
    step(1, 10, 8'h66, 8'h00, 8'h01, "R10 low only");
    step(1, 12, 8'h5A, 8'hFF, 8'hC7, "R11 reserved");
    step(0, 1, 8'hFF, 8'hFF, 8'hFF, "R2 hold");
    step(1, 1, 8'h33, 8'h44, 8'h1A, "R12 mode bits");

    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 4) != 0, $urandom % 16, $urandom % 256, $urandom % 256,
           $urandom % 256, "R2 random");
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule